// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a clocked host and an 8192 x 8 asynchronous static RAM. The RAM has a shared data bus, an active-low chip enable, an active-high chip enable, an active-low output enable and an active-low write enable. The host issues one-cycle requests: a read or a write, with a 13-bit address and a byte of write data. The controller latches the request and runs a state machine that drives the strobes, the address and the direction of the data bus. Each strobe window lasts a whole number of clock cycles, found by ceiling division of a nanosecond limit by the clock period. When a read finishes, the controller returns the captured byte together with a one-cycle done pulse.

The states are IDLE, RD_ACC (read strobes active), WR_SETUP (chip selected, write data driven, write enable still high), WR_PULSE (write enable low), WR_END (write enable high again, chip and data held), TURN (one deselected cycle with every driver off), SBY (low-power retention) and WAKE (deselected recovery after retention). The transitions are as follows. IDLE goes to SBY when standby is requested. Otherwise IDLE goes to RD_ACC or WR_SETUP when a request arrives. RD_ACC goes to TURN when its window expires. WR_SETUP goes to WR_PULSE after one cycle. WR_PULSE goes to WR_END when the pulse window expires. WR_END goes to TURN when the recovery window expires. TURN goes to IDLE after one cycle. SBY goes to WAKE when the standby request drops. WAKE goes to IDLE when the recovery window expires.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is applied and in the first cycle after it, the active-low chip enable, output enable and write enable are 1, the high chip enable is 1, the bus driver enable is 0, and busy, done and standby are 0.
- R2: An accepted read holds the active-low chip enable at 0, the high chip enable at 1, output enable at 0 and write enable at 1 for exactly N_RD consecutive cycles (10 at default timing), and the requested address is on the RAM address pins for that whole window.
- R3: At the end of the read window the controller samples the RAM bus into rdata. It then raises done for exactly one cycle, in the cycle after the strobes are released.
- R4: An accepted write selects the chip for one cycle with write enable high. It then holds write enable low for exactly N_WP cycles (7 at default: the largest of the write pulse, chip-select overlap and data setup limits). After that it keeps the chip selected with write enable high for N_WC-1-N_WP cycles, with a minimum of 1. At default timing the chip is selected for 10 cycles.
- R5: Output enable stays high for the whole write. The controller's bus driver is never enabled while output enable is low.
- R6: During the whole selected span of a write the bus driver is enabled and carries the requested write byte.
- R7: After every read or write there is one cycle in which the chip is deselected, output enable is high, the bus driver is off and busy is still 1. Idle follows in the next cycle.
- R8: Busy is 1 from the cycle after a request is accepted until the controller is idle again. Requests made while busy are ignored: they start no RAM cycle.
- R9: A standby request seen in idle, even if a host request arrives in the same cycle, sets the active-low chip enable to 1 and the high chip enable to 0 and raises the standby flag while the request is held.
- R10: Host requests are stalled during standby and wake-up: no strobe is issued. A request still held after wake-up is then served normally.
- R11: After the standby request drops, the chip stays deselected with the high chip enable at 1 and busy at 1 for exactly N_RC cycles (10 at default) before idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request, sampled only in idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Request address |
| req_wdata | input | 8 | Write byte |
| sby_req | input | 1 | Standby (retention) request, level |
| busy | output | 1 | Controller not idle |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last byte read |
| in_standby | output | 1 | Retention state active |
| ram_addr | output | 13 | RAM address |
| ram_ce1_n | output | 1 | Active-low chip enable |
| ram_ce2 | output | 1 | Active-high chip enable |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_we_n | output | 1 | Write enable, active low |
| ram_dq_out | output | 8 | Bus value driven by the controller |
| ram_dq_oe | output | 1 | Controller bus driver enable |
| ram_dq_in | input | 8 | Bus value seen from the RAM |

## Verification
The hardest case to reach is a host read that is requested during retention and held through the whole wake-up window. It must not start until the deselected recovery has run out, and then it must run as a normal read. The bench raises the standby and read requests together, holds both for several cycles, and drops only the standby request. It then counts the busy, deselected cycles until the controller is idle again, and checks the byte the delayed read returns. A second directed case pulses a read request in the middle of a write, to show that a request made while busy leaves no trace.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_END,
        ST_TURN,
        ST_SBY,
        ST_WAKE
    } ctl_state_e;

    function automatic int ns_to_clk(input int ns, input int per);
        return (ns + per - 1) / per;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_win_timer.sv
module sram_win_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (capture) begin
            dout <= din;
        end
    end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int DATA_W  = 8,
    parameter int CLK_NS  = 10,
    parameter int T_RC_NS = 100,
    parameter int T_AA_NS = 100,
    parameter int T_OA_NS = 50,
    parameter int T_WC_NS = 100,
    parameter int T_WP_NS = 60,
    parameter int T_CW_NS = 70,
    parameter int T_DS_NS = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              sby_req,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              in_standby,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_ce1_n,
    output logic              ram_ce2,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_in
);

    // Window lengths in clocks
    localparam int N_RD   = imax(ns_to_clk(T_RC_NS, CLK_NS),
                                 imax(ns_to_clk(T_AA_NS, CLK_NS), ns_to_clk(T_OA_NS, CLK_NS)));
    localparam int N_WP   = imax(ns_to_clk(T_WP_NS, CLK_NS),
                                 imax(ns_to_clk(T_CW_NS, CLK_NS), ns_to_clk(T_DS_NS, CLK_NS)));
    localparam int N_WC   = ns_to_clk(T_WC_NS, CLK_NS);
    localparam int N_WREC = ((N_WC - 1 - N_WP) > 1) ? (N_WC - 1 - N_WP) : 1;
    localparam int N_RC   = ns_to_clk(T_RC_NS, CLK_NS);
    localparam int N_MAX  = imax(imax(N_RD, N_WP), imax(N_WREC, N_RC));
    localparam int TW     = $clog2(N_MAX + 1);

    localparam logic [TW-1:0] LD_RD   = TW'(N_RD - 1);
    localparam logic [TW-1:0] LD_WP   = TW'(N_WP - 1);
    localparam logic [TW-1:0] LD_WREC = TW'(N_WREC - 1);
    localparam logic [TW-1:0] LD_RC   = TW'(N_RC - 1);

    ctl_state_e    state_q, state_d;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          take_req;

    sram_win_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    sram_rd_capture #(.DW(DATA_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (state_q == ST_RD_ACC && tmr_zero),
        .din     (ram_dq_in),
        .dout    (rdata)
    );

    // Next state and window loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (sby_req) begin
                    state_d = ST_SBY;
                end else if (req_valid) begin
                    if (req_write) begin
                        state_d = ST_WR_SETUP;
                    end else begin
                        state_d  = ST_RD_ACC;
                        tmr_load = 1'b1;
                        tmr_val  = LD_RD;
                    end
                end
            end
            ST_RD_ACC:   if (tmr_zero) state_d = ST_TURN;
            ST_WR_SETUP: begin
                state_d  = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = LD_WP;
            end
            ST_WR_PULSE: begin
                if (tmr_zero) begin
                    state_d  = ST_WR_END;
                    tmr_load = 1'b1;
                    tmr_val  = LD_WREC;
                end
            end
            ST_WR_END:   if (tmr_zero) state_d = ST_TURN;
            ST_TURN:     state_d = ST_IDLE;
            ST_SBY: begin
                if (!sby_req) begin
                    state_d  = ST_WAKE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_RC;
                end
            end
            ST_WAKE:     if (tmr_zero) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    assign take_req = (state_q == ST_IDLE) && !sby_req && req_valid;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_ce1_n  <= 1'b1;
            ram_ce2    <= 1'b1;
            ram_oe_n   <= 1'b1;
            ram_we_n   <= 1'b1;
            ram_dq_oe  <= 1'b0;
            ram_addr   <= '0;
            ram_dq_out <= '0;
            busy       <= 1'b0;
            done       <= 1'b0;
            in_standby <= 1'b0;
        end else begin
            if (take_req) begin
                ram_addr   <= req_addr;
                ram_dq_out <= req_wdata;
            end
            ram_ce1_n  <= !(state_d inside {ST_RD_ACC, ST_WR_SETUP, ST_WR_PULSE, ST_WR_END});
            ram_ce2    <= (state_d != ST_SBY);
            ram_oe_n   <= (state_d != ST_RD_ACC);
            ram_we_n   <= (state_d != ST_WR_PULSE);
            ram_dq_oe  <= (state_d inside {ST_WR_SETUP, ST_WR_PULSE, ST_WR_END});
            busy       <= (state_d != ST_IDLE);
            done       <= (state_d == ST_TURN);
            in_standby <= (state_d == ST_SBY);
        end
    end

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
    parameter int AW   = 13,
    parameter int N_WP = 7,
    parameter int N_RD = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ram_ce1_n,
    input logic          ram_ce2,
    input logic          ram_oe_n,
    input logic          ram_we_n,
    input logic          ram_dq_oe,
    input logic          busy,
    input logic          done,
    input logic          in_standby,
    input logic [AW-1:0] ram_addr
);

    logic [15:0] we_low_cnt;
    logic [15:0] oe_low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_low_cnt <= '0;
            oe_low_cnt <= '0;
        end else begin
            we_low_cnt <= ram_we_n ? 16'd0 : we_low_cnt + 16'd1;
            oe_low_cnt <= ram_oe_n ? 16'd0 : oe_low_cnt + 16'd1;
        end
    end

    // R5
    drv_vs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_dq_oe |-> ram_oe_n);

    // R4
    we_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (!ram_ce1_n && ram_ce2 && ram_oe_n));

    // R4
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> (we_low_cnt == 16'(N_WP)));

    // R2
    rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_oe_n) |-> (oe_low_cnt == 16'(N_RD)));

    // R2
    rd_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_oe_n |-> (!ram_ce1_n && ram_ce2 && ram_we_n));

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_ce1_n && $past(!ram_ce1_n)) |-> $stable(ram_addr));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    turn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ram_ce1_n && ram_oe_n && !ram_dq_oe && busy));

    // R9
    standby_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_standby |-> (ram_ce1_n && !ram_ce2 && busy));

    // R8
    idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ram_ce1_n && ram_we_n && ram_oe_n));

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
    .AW   (ADDR_W),
    .N_WP (N_WP),
    .N_RD (N_RD)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ram_ce1_n  (ram_ce1_n),
    .ram_ce2    (ram_ce2),
    .ram_oe_n   (ram_oe_n),
    .ram_we_n   (ram_we_n),
    .ram_dq_oe  (ram_dq_oe),
    .busy       (busy),
    .done       (done),
    .in_standby (in_standby),
    .ram_addr   (ram_addr)
);

// File: tb/sram_strobe_ctrl_tb.sv
module sram_strobe_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int EXP_RD     = (100 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int EXP_WP     = (70 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int EXP_WSPAN  = (100 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int EXP_WAKE   = (100 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int NVEC       = 8;

    // {write, addr[12:0], data[7:0]}
    localparam logic [21:0] VEC [NVEC] = '{
        {1'b1, 13'h0005, 8'h3C},
        {1'b1, 13'h1FFF, 8'hA5},
        {1'b1, 13'h0012, 8'h81},
        {1'b0, 13'h0005, 8'h3C},
        {1'b0, 13'h1FFF, 8'hA5},
        {1'b1, 13'h0005, 8'hFF},
        {1'b0, 13'h0005, 8'hFF},
        {1'b0, 13'h0012, 8'h81}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        sby_req = 1'b0;
    logic        busy, done, in_standby;
    logic [7:0]  rdata;
    logic [12:0] ram_addr;
    logic        ram_ce1_n, ram_ce2, ram_oe_n, ram_we_n, ram_dq_oe;
    logic [7:0]  ram_dq_out;
    logic [7:0]  ram_dq_in;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sram_strobe_ctrl #(.CLK_NS(CLK_PERIOD)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .sby_req    (sby_req),
        .busy       (busy),
        .done       (done),
        .rdata      (rdata),
        .in_standby (in_standby),
        .ram_addr   (ram_addr),
        .ram_ce1_n  (ram_ce1_n),
        .ram_ce2    (ram_ce2),
        .ram_oe_n   (ram_oe_n),
        .ram_we_n   (ram_we_n),
        .ram_dq_out (ram_dq_out),
        .ram_dq_oe  (ram_dq_oe),
        .ram_dq_in  (ram_dq_in)
    );

    // Small RAM model, indexed by the low address bits
    logic [7:0] mem [64];
    initial for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    always @(posedge ram_we_n) begin
        if (ram_ce1_n === 1'b0 && ram_ce2 === 1'b1) mem[ram_addr[5:0]] <= ram_dq_out;
    end
    assign ram_dq_in = (!ram_ce1_n && ram_ce2 && !ram_oe_n) ? mem[ram_addr[5:0]] : 8'h00;

    // Pin monitor
    int          we_run = 0, last_wp = 0;
    int          rd_run = 0, last_rd = 0, rd_total = 0;
    int          ce_run = 0, last_ce = 0;
    logic [7:0]  wr_seen = '0;
    logic        wr_drv_seen = 1'b0;
    logic [12:0] rd_addr_seen = '0;
    logic        conflict = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!ram_we_n) begin
                we_run++;
            end else if (we_run > 0) begin
                last_wp = we_run;
                we_run  = 0;
            end
            if (!ram_oe_n && !ram_ce1_n) begin
                rd_run++;
                rd_total++;
                rd_addr_seen = ram_addr;
            end else if (rd_run > 0) begin
                last_rd = rd_run;
                rd_run  = 0;
            end
            if (!ram_ce1_n) begin
                ce_run++;
                if (!ram_oe_n == 1'b0) begin
                    wr_seen     = ram_dq_out;
                    wr_drv_seen = ram_dq_oe;
                end
            end else if (ce_run > 0) begin
                last_ce = ce_run;
                ce_run  = 0;
            end
            if (ram_dq_oe && !ram_oe_n) conflict = 1'b1;
            if (!ram_we_n && !ram_oe_n) conflict = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            finish_run();
        end
    end

    task automatic wait_done();
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (done) break;
        end
    endtask

    task automatic run_op(input logic wr, input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        // R7 turnaround cycle
        chk(done && ram_ce1_n && ram_oe_n && !ram_dq_oe && busy, "R7 turnaround",
            {ram_ce1_n, ram_oe_n, ram_dq_oe, busy}, 4'b1101);
        if (!wr) chk(rdata == d, "R3 read data", rdata, d);
        @(negedge clk);
        chk(!done, "R3 done single cycle", done, 0);
        chk(!busy, "R8 busy cleared", busy, 0);
        if (wr) begin
            chk(last_wp == EXP_WP, "R4 write pulse width", last_wp, EXP_WP);
            chk(last_ce == EXP_WSPAN, "R4 write select span", last_ce, EXP_WSPAN);
            chk(wr_seen == d && wr_drv_seen, "R6 write data driven", wr_seen, d);
        end else begin
            chk(last_rd == EXP_RD, "R2 read window", last_rd, EXP_RD);
            chk(rd_addr_seen == a, "R2 read address", rd_addr_seen, a);
        end
    endtask

    initial begin
        // R1 reset values
        repeat (3) @(negedge clk);
        chk({ram_ce1_n, ram_ce2, ram_oe_n, ram_we_n, ram_dq_oe, busy, done, in_standby} == 8'b1111_0000,
            "R1 reset outputs", {ram_ce1_n, ram_ce2, ram_oe_n, ram_we_n, ram_dq_oe, busy, done, in_standby},
            8'b1111_0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk({ram_ce1_n, ram_ce2, ram_oe_n, ram_we_n, ram_dq_oe, busy} == 6'b111100,
            "R1 after reset", {ram_ce1_n, ram_ce2, ram_oe_n, ram_we_n, ram_dq_oe, busy}, 6'b111100);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            run_op(VEC[v][21], VEC[v][20:8], VEC[v][7:0]);
        end

        // R8: request while busy is ignored
        begin
            int rd_before;
            rd_before = rd_total;
            @(negedge clk);
            req_valid = 1'b1; req_write = 1'b1; req_addr = 13'h0020; req_wdata = 8'h5A;
            @(negedge clk);
            req_valid = 1'b0;
            @(negedge clk);
            chk(busy, "R8 busy during write", busy, 1);
            req_valid = 1'b1; req_write = 1'b0; req_addr = 13'h0007;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
            wait_done();
            repeat (4) @(negedge clk);
            chk(rd_total == rd_before, "R8 busy request ignored", rd_total, rd_before);
            chk(!busy, "R8 idle after ignored request", busy, 0);
        end

        // R9/R10/R11: standby with a stalled read
        begin
            int rd_before;
            int wake_cnt;
            rd_before = rd_total;
            @(negedge clk);
            sby_req = 1'b1;
            req_valid = 1'b1; req_write = 1'b0; req_addr = 13'h1FFF;
            @(negedge clk);
            chk(ram_ce1_n && !ram_ce2 && in_standby && busy, "R9 standby entry",
                {ram_ce1_n, ram_ce2, in_standby, busy}, 4'b1011);
            repeat (5) @(negedge clk);
            chk(in_standby && !ram_ce2, "R9 standby held", {in_standby, ram_ce2}, 2'b10);
            chk(rd_total == rd_before, "R10 no strobes in standby", rd_total, rd_before);
            sby_req = 1'b0;
            @(negedge clk);
            chk(!in_standby && ram_ce2 && ram_ce1_n, "R11 wake deselected",
                {in_standby, ram_ce2, ram_ce1_n}, 3'b011);
            wake_cnt = 1;
            for (int k = 0; k < 50; k++) begin
                @(negedge clk);
                if (!busy) break;
                chk(ram_ce1_n, "R10 no strobes during wake", ram_ce1_n, 1);
                wake_cnt++;
            end
            chk(wake_cnt == EXP_WAKE, "R11 wake length", wake_cnt, EXP_WAKE);
            @(negedge clk);
            req_valid = 1'b0;
            chk(busy && !ram_ce1_n, "R10 stalled read starts", {busy, ram_ce1_n}, 2'b10);
            wait_done();
            chk(rdata == 8'hA5, "R10 stalled read data", rdata, 8'hA5);
            @(negedge clk);
        end

        chk(!conflict, "R5 no bus conflict", conflict, 0);
        finish_run();
    end

endmodule